// File: doc/BRIEF.md
# Scanline-Counting Interrupt Generator

This block counts visible display lines and raises an interrupt request to the CPU once a programmed number of lines has gone by. Software programs the line count through a small set of write-only registers on the CPU bus. The video side supplies a pulse once per line, together with the line number and a flag that says whether rendering is active. The request stays asserted until software acknowledges it. The current counter value is also available on a port.

A reload request can arrive while lines are being drawn or during vertical blank, and the block handles the two cases differently. A request made during blank is held until the first counted line. On that line the latch is loaded and then counted down in the same step. A request made during the visible area causes a plain load on the next counted line. A latch value of zero suppresses the interrupt completely, so software can use it as a cheap way to turn the interrupt off.

Top module: `scanline_irq_unit`

## Requirements
- R1: While reset is asserted and after it is released, the counter reads 0, the interrupt is low, the enable is off and the reload latch holds 0xFF.
- R2: Register selection uses only the address bits in `wr_addr_i & 0xE001`. A selected address of 0xC000 stores the data byte in the reload latch. Writes that select any other value, such as 0x8000 or 0xA001, have no effect.
- R3: A write that selects 0xC001 sets bit 7 of the counter. The new value is visible on `count_o` one cycle after the write. If `line_num_i` is below 240 at the time of the write, the write arms a visible reload. Otherwise it arms a blank reload and clears any armed visible reload.
- R4: The counter steps only when `line_pulse_i` is high, `line_num_i` is below 240 and `render_en_i` is high. Any other pulse leaves the counter and the interrupt unchanged.
- R5: On a step, an armed blank reload first loads the latch into the counter and disarms itself. Next, an armed visible reload loads the latch and disarms itself. If no visible reload is armed, a nonzero counter decrements by one. A blank reload alone therefore gives latch minus 1.
- R6: If the counter is zero after a step, a visible reload is armed. The next step then loads the latch again.
- R7: A step that leaves the counter at zero raises `irq_o` when the interrupt is enabled and the latch is nonzero. It never raises `irq_o` when the latch is zero.
- R8: Once `irq_o` is high, it stays high until a write selecting 0xE000 or 0xE001, or a reset.
- R9: A write that selects 0xE000 disables the interrupt and clears `irq_o`. A write that selects 0xE001 enables the interrupt and clears `irq_o`.
- R10: When a register write and a line step fall in the same cycle, the write takes effect first. The step then uses the new latch, enable and reload flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| line_pulse_i | input | 1 | One-cycle pulse per display line |
| line_num_i | input | 9 | Current line number |
| render_en_i | input | 1 | Rendering active flag |
| irq_o | output | 1 | Interrupt request, held until acknowledged |
| count_o | output | 8 | Current counter value |

## Verification
A CPU register write and a line step can land in the same clock cycle. The order between them decides the outcome: it sets which latch value gets loaded, whether an acknowledge or an enable wins over a new zero hit, and which reload flag is acted on. The bench provokes this collision on purpose in directed cases: it pairs an enable write and a disable write with a line that reaches zero, and a latch write with a line that reloads. Random stimulus also produces many more such collisions. In every case the outputs are compared with a bench model that applies the write before the step.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef struct packed {
    logic latch_wr;
    logic reload_wr;
    logic disable_wr;
    logic enable_wr;
  } sirq_cmd_t;

  localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 16'hE001,
  parameter logic [ADDR_W-1:0] ADDR_LATCH = 16'hC000,
  parameter logic [ADDR_W-1:0] ADDR_RELOAD = 16'hC001,
  parameter logic [ADDR_W-1:0] ADDR_DISABLE = 16'hE000,
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = 16'hE001
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output sirq_cmd_t         cmd_o
);
  localparam logic [ADDR_W-1:0] REG_ADDR [NUM_REGS] =
    '{ADDR_LATCH, ADDR_RELOAD, ADDR_DISABLE, ADDR_ENABLE};

  logic [ADDR_W-1:0]   masked_addr;
  logic [NUM_REGS-1:0] hit;

  assign masked_addr = wr_addr_i & ADDR_MASK;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = wr_en_i && (masked_addr == REG_ADDR[g]);
  end

  assign cmd_o.latch_wr   = hit[0];
  assign cmd_o.reload_wr  = hit[1];
  assign cmd_o.disable_wr = hit[2];
  assign cmd_o.enable_wr  = hit[3];
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter
  import sirq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LINE_W = 9,
  parameter int unsigned VISIBLE_LINES = 240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sirq_cmd_t         cmd_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              line_pulse_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] latch_o,
  output logic [DATA_W-1:0] latch_next_o,
  output logic              zero_hit_o
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [LINE_W-1:0] VIS_LIM = LINE_W'(VISIBLE_LINES);

  logic [DATA_W-1:0] cnt_q, cnt_w, cnt_d, latch_q, latch_w;
  logic vis_q, vis_w, vis_d, vbl_q, vbl_w, vbl_d;
  logic in_visible, step;

  assign in_visible = line_num_i < VIS_LIM;
  assign step       = line_pulse_i && in_visible && render_en_i;

  // register write stage, applied before the line step
  always_comb begin
    latch_w = cmd_i.latch_wr ? wr_data_i : latch_q;
    cnt_w   = cnt_q;
    vis_w   = vis_q;
    vbl_w   = vbl_q;
    if (cmd_i.reload_wr) begin
      cnt_w[MSB] = 1'b1;
      if (in_visible) begin
        vis_w = 1'b1;
      end else begin
        vbl_w = 1'b1;
        vis_w = 1'b0;
      end
    end
  end

  // line step stage
  always_comb begin
    cnt_d      = cnt_w;
    vis_d      = vis_w;
    vbl_d      = vbl_w;
    zero_hit_o = 1'b0;
    if (step) begin
      if (vbl_w) begin
        cnt_d = latch_w;
        vbl_d = 1'b0;
      end
      if (vis_w) begin
        cnt_d = latch_w;
        vis_d = 1'b0;
      end else if (cnt_d != '0) begin
        cnt_d = cnt_d - 1'b1;
      end
      if (cnt_d == '0) begin
        vis_d      = 1'b1;
        zero_hit_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      latch_q <= '1;
      vis_q   <= 1'b0;
      vbl_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      latch_q <= latch_w;
      vis_q   <= vis_d;
      vbl_q   <= vbl_d;
    end
  end

  assign count_o      = cnt_q;
  assign latch_o      = latch_q;
  assign latch_next_o = latch_w;

  a_r4_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !cmd_i.reload_wr) |=> $stable(count_o));
  a_r3_msb_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.reload_wr && !step) |=> count_o[MSB]);
  a_r6_zero_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_hit_o |=> (vis_q && count_o == '0));
  a_r2_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i.latch_wr |=> $stable(latch_o));
endmodule

// File: rtl/sirq_irq.sv
module sirq_irq
  import sirq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sirq_cmd_t         cmd_i,
  input  logic              zero_hit_i,
  input  logic [DATA_W-1:0] latch_i,
  output logic              irq_o,
  output logic              enable_o
);
  logic en_q, en_w, pend_q, pend_d, ack;

  assign ack  = cmd_i.disable_wr || cmd_i.enable_wr;
  assign en_w = cmd_i.enable_wr ? 1'b1 : (cmd_i.disable_wr ? 1'b0 : en_q);

  always_comb begin
    pend_d = ack ? 1'b0 : pend_q;
    // zero latch suppresses firing
    if (zero_hit_i && en_w && (latch_i != '0)) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_w;
      pend_q <= pend_d;
    end
  end

  assign irq_o    = pend_q;
  assign enable_o = en_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack) |=> irq_o);
  a_r9_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !zero_hit_i) |=> !irq_o);
  a_r9_disable_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.disable_wr |=> (!irq_o && !enable_o));
  a_r7_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> enable_o);
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import sirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LINE_W = 9,
  parameter int unsigned VISIBLE_LINES = 240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              line_pulse_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] count_o
);
  sirq_cmd_t         cmd;
  logic [DATA_W-1:0] latch, latch_next;
  logic              zero_hit, enable;

  sirq_decode #(.ADDR_W(ADDR_W)) i_decode (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .cmd_o    (cmd)
  );

  sirq_counter #(
    .DATA_W(DATA_W), .LINE_W(LINE_W), .VISIBLE_LINES(VISIBLE_LINES)
  ) i_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .wr_data_i   (wr_data_i),
    .line_pulse_i(line_pulse_i),
    .line_num_i  (line_num_i),
    .render_en_i (render_en_i),
    .count_o     (count_o),
    .latch_o     (latch),
    .latch_next_o(latch_next),
    .zero_hit_o  (zero_hit)
  );

  sirq_irq #(.DATA_W(DATA_W)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .zero_hit_i(zero_hit),
    .latch_i   (latch_next),
    .irq_o     (irq_o),
    .enable_o  (enable)
  );

  a_r7_zero_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (latch != '0 && count_o == '0));
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && count_o == '0 && !enable));
endmodule

// File: tb/test_scanline_irq_unit.sv
`timescale 1ns/1ps
module test_scanline_irq_unit;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [15:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic line_pulse_i = 1'b0;
  logic [8:0] line_num_i = '0;
  logic render_en_i = 1'b0;
  logic irq_o;
  logic [7:0] count_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m_cnt, m_latch;
  logic m_vis, m_vbl, m_en, m_pend;

  always #4 clk_i = ~clk_i;

  scanline_irq_unit i_scanline_irq_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .line_pulse_i(line_pulse_i), .line_num_i(line_num_i),
    .render_en_i(render_en_i), .irq_o(irq_o), .count_o(count_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sel(input logic [15:0] a);
    return a & 16'hE001;
  endfunction

  task automatic model_reset();
    m_cnt = 8'h00; m_latch = 8'hFF; m_vis = 0; m_vbl = 0; m_en = 0; m_pend = 0;
  endtask

  task automatic model_step(input logic we, input logic [15:0] a, input logic [7:0] d,
                            input logic p, input logic [8:0] ln, input logic ren);
    if (we) begin
      case (sel(a))
        16'hC000: m_latch = d;
        16'hC001: begin
          m_cnt[7] = 1'b1;
          if (ln < 240) m_vis = 1'b1;
          else begin m_vbl = 1'b1; m_vis = 1'b0; end
        end
        16'hE000: begin m_en = 1'b0; m_pend = 1'b0; end
        16'hE001: begin m_en = 1'b1; m_pend = 1'b0; end
        default: ;
      endcase
    end
    if (p && ln < 240 && ren) begin
      if (m_vbl) begin m_cnt = m_latch; m_vbl = 1'b0; end
      if (m_vis) begin m_cnt = m_latch; m_vis = 1'b0; end
      else if (m_cnt != 0) m_cnt = m_cnt - 1'b1;
      if (m_cnt == 0) begin
        m_vis = 1'b1;
        if (m_en && m_latch != 0) m_pend = 1'b1;
      end
    end
  endtask

  task automatic cyc(input logic we, input logic [15:0] a, input logic [7:0] d,
                     input logic p, input logic [8:0] ln, input logic ren, input string tag);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    line_pulse_i = p; line_num_i = ln; render_en_i = ren;
    @(posedge clk_i);
    model_step(we, a, d, p, ln, ren);
    @(negedge clk_i);
    wr_en_i = 0; line_pulse_i = 0;
    check(tag, "count", count_o, m_cnt);
    check(tag, "irq", {7'd0, irq_o}, {7'd0, m_pend});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [8:0] ln,
                    input string tag);
    cyc(1'b1, a, d, 1'b0, ln, 1'b1, tag);
  endtask

  task automatic line(input logic [8:0] ln, input logic ren, input string tag);
    cyc(1'b0, 16'h0, 8'h0, 1'b1, ln, ren, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    model_reset();
    repeat (3) @(negedge clk_i);
    check("R1", "count in reset", count_o, 8'h00);
    check("R1", "irq in reset", {7'd0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "count after reset", count_o, 8'h00);

    // blank reload then first line: latch FF loaded then decremented
    wr(16'hC001, 8'h00, 9'd250, "R3");
    check("R3", "msb set", count_o, 8'h80);
    line(9'd0, 1'b1, "R5");
    check("R5", "blank reload minus one", count_o, 8'hFE);
    line(9'd240, 1'b1, "R4");
    line(9'd5, 1'b0, "R4");
    check("R4", "no step", count_o, 8'hFE);
    // alias of latch address, ignored selections
    wr(16'hC0F0, 8'h03, 9'd10, "R2");
    wr(16'h8000, 8'h07, 9'd10, "R2");
    wr(16'hA001, 8'h07, 9'd10, "R2");
    wr(16'hC001, 8'h00, 9'd10, "R3");
    line(9'd11, 1'b1, "R5");
    check("R2", "latch value loaded", count_o, 8'h03);
    wr(16'hE001, 8'h00, 9'd11, "R9");
    line(9'd12, 1'b1, "R5");
    line(9'd13, 1'b1, "R5");
    line(9'd14, 1'b1, "R7");
    check("R7", "irq at zero", {7'd0, irq_o}, 8'h01);
    line(9'd15, 1'b1, "R6");
    check("R6", "reload after zero", count_o, 8'h03);
    line(9'd16, 1'b1, "R8");
    line(9'd241, 1'b1, "R8");
    check("R8", "irq held", {7'd0, irq_o}, 8'h01);
    wr(16'hE000, 8'h00, 9'd17, "R9");
    check("R9", "disable clears", {7'd0, irq_o}, 8'h00);
    // zero latch never fires
    wr(16'hC000, 8'h00, 9'd18, "R7");
    wr(16'hE001, 8'h00, 9'd18, "R7");
    wr(16'hC001, 8'h00, 9'd18, "R7");
    line(9'd19, 1'b1, "R7");
    line(9'd20, 1'b1, "R7");
    check("R7", "zero latch silent", {7'd0, irq_o}, 8'h00);
    // same-cycle collisions
    wr(16'hC000, 8'h02, 9'd21, "R10");
    wr(16'hE000, 8'h00, 9'd21, "R10");
    line(9'd22, 1'b1, "R10");
    line(9'd23, 1'b1, "R10");
    cyc(1'b1, 16'hE001, 8'h00, 1'b1, 9'd24, 1'b1, "R10");
    check("R10", "enable then zero fires", {7'd0, irq_o}, 8'h01);
    cyc(1'b1, 16'hC000, 8'h05, 1'b1, 9'd25, 1'b1, "R10");
    check("R10", "new latch used by reload", count_o, 8'h05);
    repeat (4) line(9'd26, 1'b1, "R10");
    cyc(1'b1, 16'hE000, 8'h00, 1'b1, 9'd30, 1'b1, "R10");
    check("R10", "disable beats zero", {7'd0, irq_o}, 8'h00);
    // blank request clears armed visible reload
    wr(16'hC001, 8'h00, 9'd31, "R3");
    wr(16'hC001, 8'h00, 9'd245, "R3");
    line(9'd0, 1'b1, "R5");
    check("R5", "blank path minus one", count_o, 8'h04);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic we;
      case ($urandom_range(0, 7))
        0: a = 16'hC000; 1: a = 16'hC001; 2: a = 16'hE000; 3: a = 16'hE001;
        4: a = 16'hC000 | 16'($urandom_range(0, 16'h1FFE) & 16'h1FFE);
        5: a = 16'h8000; 6: a = 16'hA001;
        default: a = 16'($urandom());
      endcase
      we = ($urandom_range(0, 4) == 0);
      cyc(we, a, 8'($urandom_range(0, 6)), $urandom_range(0, 2) != 0,
          9'($urandom_range(0, 261)), $urandom_range(0, 9) != 0, "R10");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule